// File: doc/BRIEF.md
# Object Attribute Memory Copy Engine

This block copies a fixed run of 160 bytes from anywhere in the 16-bit address space into the sprite attribute table, one byte at a time. A start strobe carries the 16-bit source base. The first byte moves after a fixed start-up delay, and each following byte after a shorter fixed interval. The source port reads one byte and the table write port stores it in the same cycle. The table index counts up from zero and the source address counts up from the base.

While a copy is running, the block also filters the CPU bus. The CPU is locked out of the attribute table and of a second window. That window depends on the 8 KiB region the source lies in and on the model strap. A locked-out read returns 0xFF and a locked-out write is dropped. Any other access passes through unchanged, and nothing is filtered while the engine is idle. A new start during a copy abandons the old copy and begins again from the new base.

Top module: `oam_copy_engine`

## Requirements
- R1: A start with a base above 0xF100 arriving while idle is ignored: busy stays low and no table write follows. A base of exactly 0xF100 is accepted.
- R2: Call E0 the clock edge that samples start. Byte 0 is strobed in the cycle that ends at edge E0+8, and byte k in the cycle that ends at edge E0+8+4k.
- R3: Exactly 160 bytes are written, at table indices 0 to 159 in order. Byte k carries the source data read at address base+k in the same cycle.
- R4: During a copy, CPU reads of 0xFE00–0xFE9F return 0xFF and CPU writes there are dropped. Address 0xFEA0 is not affected by this rule.
- R5: With model strap 0 (original), a source whose bits [15:13] equal 3'b100 locks 0x8000–0x9FFF. Any other source locks 0xA000–0xFDFF.
- R6: With model strap 1 (colour), a source whose bits [15:13] equal 3'b100 locks 0x8000–0x9FFF. Bits [15:13] equal to 3'b110 lock 0xC000–0xFDFF, and any other value locks 0xA000–0xBFFF.
- R7: A CPU access outside every locked range, or any access while idle, passes through: read data equals the bus data and the write enable equals the CPU write request.
- R8: Busy rises at edge E0 and stays high through the cycle of byte 159. After that cycle, busy is low and filtering has ended.
- R9: An accepted start during a copy restarts it from the new base with a fresh 8-cycle delay. A byte strobed in the same cycle as the restarting start is still written.
- R10: After reset, busy is low and no table or source strobe is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, one cycle |
| start_base_i | input | 16 | Source base address for the copy |
| color_mode_i | input | 1 | Model strap: 0 original, 1 colour |
| cpu_addr_i | input | 16 | CPU bus address |
| cpu_rd_i | input | 1 | CPU read request |
| cpu_wr_i | input | 1 | CPU write request |
| cpu_bus_rdata_i | input | 8 | Read data returned by the system bus |
| cpu_rdata_o | output | 8 | Filtered read data to the CPU |
| mem_wr_o | output | 1 | Filtered write enable to the system bus |
| src_rd_o | output | 1 | Source byte read strobe |
| src_addr_o | output | 16 | Source byte address |
| src_rdata_i | input | 8 | Source byte data, same cycle |
| oam_we_o | output | 1 | Attribute table write strobe |
| oam_idx_o | output | 8 | Attribute table byte index |
| oam_wdata_o | output | 8 | Attribute table write data |
| busy_o | output | 1 | Copy in progress |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is a CPU write to the attribute table in the cycle where the engine strobes a table byte. The bench waits for the cycle of byte 0 and raises a CPU write to 0xFE00 there. It expects the write to be dropped while the engine's own write still takes place. The second pair is a restart timed onto the cycle of byte 159. The scoreboard must then see that final byte, then a fresh schedule from the new base starting 8 cycles later, and busy must never drop in between.

// File: rtl/oam_dma_pkg.sv
package oam_dma_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int REGION_W = 3;

  localparam logic [ADDR_W-1:0] OAM_LO = 16'hFE00;
  localparam logic [ADDR_W-1:0] OAM_END = 16'hFEA0;

  typedef struct packed {
    logic [ADDR_W-1:0] lo;
    logic [ADDR_W-1:0] hi;
  } window_t;

  // Locked window for a given source region and model strap (hi is exclusive).
  function automatic window_t lock_window(input logic [REGION_W-1:0] region,
                                          input logic color);
    window_t w;
    if (region == 3'b100) begin
      w.lo = 16'h8000;
      w.hi = 16'hA000;
    end else if (!color) begin
      w.lo = 16'hA000;
      w.hi = 16'hFE00;
    end else if (region == 3'b110) begin
      w.lo = 16'hC000;
      w.hi = 16'hFE00;
    end else begin
      w.lo = 16'hA000;
      w.hi = 16'hC000;
    end
    return w;
  endfunction

endpackage

// File: rtl/oam_dma_seq.sv
module oam_dma_seq
  import oam_dma_pkg::*;
#(
  parameter int NUM_BYTES   = 160,
  parameter int FIRST_DELAY = 8,
  parameter int BYTE_PERIOD = 4,
  parameter logic [ADDR_W-1:0] MAX_BASE = 16'hF100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [ADDR_W-1:0]   base_i,
  output logic                active_o,
  output logic                beat_o,
  output logic [ADDR_W-1:0]   src_addr_o,
  output logic [7:0]          idx_o,
  output logic [REGION_W-1:0] region_o
);

  localparam int CNT_W = $clog2(FIRST_DELAY);
  localparam int IDX_W = $clog2(NUM_BYTES);
  localparam logic [CNT_W-1:0] FIRST_LOAD  = CNT_W'(FIRST_DELAY - 1);
  localparam logic [CNT_W-1:0] PERIOD_LOAD = CNT_W'(BYTE_PERIOD - 1);
  localparam logic [IDX_W-1:0] LAST_IDX    = IDX_W'(NUM_BYTES - 1);

  logic                active_q, active_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [ADDR_W-1:0]   src_q, src_d;
  logic [REGION_W-1:0] region_q, region_d;
  logic                start_ok, beat, last_beat, state_en;

  assign start_ok  = start_i && (base_i <= MAX_BASE);
  assign beat      = active_q && (cnt_q == '0);
  assign last_beat = beat && (idx_q == LAST_IDX);
  assign state_en  = start_ok || active_q;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    src_d    = src_q;
    region_d = region_q;
    if (start_ok) begin
      active_d = 1'b1;
      cnt_d    = FIRST_LOAD;
      idx_d    = '0;
      src_d    = base_i;
      region_d = base_i[ADDR_W-1 -: REGION_W];
    end else if (beat) begin
      if (last_beat) begin
        active_d = 1'b0;
      end else begin
        idx_d = idx_q + 1'b1;
        src_d = src_q + 1'b1;
        cnt_d = PERIOD_LOAD;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      idx_q    <= '0;
      src_q    <= '0;
      region_q <= '0;
    end else if (state_en) begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      src_q    <= src_d;
      region_q <= region_d;
    end
  end

  assign active_o   = active_q;
  assign beat_o     = beat;
  assign src_addr_o = src_q;
  assign idx_o      = 8'(idx_q);
  assign region_o   = region_q;

  // R2: strobes are spaced, never back to back
  assert_beat_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> !beat_o);

  // R3: index stays within the copy length
  assert_idx_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_o |-> (idx_o < 8'(NUM_BYTES)));

  // R8: activity ends only right after the final byte
  assert_end_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> $past(beat_o && (idx_o == 8'(NUM_BYTES - 1))));

  // R1: out-of-range start while idle leaves the engine idle
  assert_ignore_high_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (base_i > MAX_BASE) && !active_o) |=> !active_o);

  // R9: accepted start gives a fresh delay from index zero
  assert_restart_fresh_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> (active_o && !beat_o && idx_o == 8'd0 && src_addr_o == $past(base_i)));

endmodule

// File: rtl/oam_dma_guard.sv
module oam_dma_guard
  import oam_dma_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                active_i,
  input  logic [REGION_W-1:0] region_i,
  input  logic                color_i,
  input  logic [ADDR_W-1:0]   cpu_addr_i,
  input  logic                cpu_wr_i,
  input  logic [DATA_W-1:0]   bus_rdata_i,
  output logic [DATA_W-1:0]   cpu_rdata_o,
  output logic                mem_wr_o
);

  window_t win;
  logic    in_oam, in_win, blocked;

  always_comb begin
    win     = lock_window(region_i, color_i);
    in_oam  = (cpu_addr_i >= OAM_LO) && (cpu_addr_i < OAM_END);
    in_win  = (cpu_addr_i >= win.lo) && (cpu_addr_i < win.hi);
    blocked = active_i && (in_oam || in_win);
    cpu_rdata_o = blocked ? '1 : bus_rdata_i;
    mem_wr_o    = cpu_wr_i && !blocked;
  end

  // R4: table accesses are always locked during a copy
  assert_oam_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_i && cpu_addr_i[15:8] == 8'hFE && cpu_addr_i[7:0] < 8'hA0)
      |-> (!mem_wr_o && cpu_rdata_o == 8'hFF));

endmodule

// File: rtl/oam_copy_engine.sv
module oam_copy_engine
  import oam_dma_pkg::*;
#(
  parameter int NUM_BYTES   = 160,
  parameter int FIRST_DELAY = 8,
  parameter int BYTE_PERIOD = 4,
  parameter logic [15:0] MAX_BASE = 16'hF100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [15:0] start_base_i,
  input  logic        color_mode_i,
  input  logic [15:0] cpu_addr_i,
  input  logic        cpu_rd_i,
  input  logic        cpu_wr_i,
  input  logic [7:0]  cpu_bus_rdata_i,
  output logic [7:0]  cpu_rdata_o,
  output logic        mem_wr_o,
  output logic        src_rd_o,
  output logic [15:0] src_addr_o,
  input  logic [7:0]  src_rdata_i,
  output logic        oam_we_o,
  output logic [7:0]  oam_idx_o,
  output logic [7:0]  oam_wdata_o,
  output logic        busy_o
);

  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic                active, beat;
  logic [REGION_W-1:0] region;
  logic                rd_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  oam_dma_seq #(
    .NUM_BYTES  (NUM_BYTES),
    .FIRST_DELAY(FIRST_DELAY),
    .BYTE_PERIOD(BYTE_PERIOD),
    .MAX_BASE   (MAX_BASE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start_i   (start_i),
    .base_i    (start_base_i),
    .active_o  (active),
    .beat_o    (beat),
    .src_addr_o(src_addr_o),
    .idx_o     (oam_idx_o),
    .region_o  (region)
  );

  oam_dma_guard u_guard (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .active_i   (active),
    .region_i   (region),
    .color_i    (color_mode_i),
    .cpu_addr_i (cpu_addr_i),
    .cpu_wr_i   (cpu_wr_i),
    .bus_rdata_i(cpu_bus_rdata_i),
    .cpu_rdata_o(cpu_rdata_o),
    .mem_wr_o   (mem_wr_o)
  );

  assign rd_unused   = cpu_rd_i;
  assign src_rd_o    = beat;
  assign oam_we_o    = beat;
  assign oam_wdata_o = src_rdata_i;
  assign busy_o      = active;

  // R7: idle engine never filters
  assert_idle_pass_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> (mem_wr_o == cpu_wr_i && cpu_rdata_o == cpu_bus_rdata_i));

  // R10: no strobes while idle
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !busy_o |-> (!oam_we_o && !src_rd_o));

endmodule

// File: tb/tb_oam_copy_engine.sv
module tb_oam_copy_engine;

  localparam int CLK_PERIOD = 10;
  localparam int NBYTES = 160;
  localparam int WATCHDOG = 150000;
  localparam logic [7:0] BUSDATA = 8'h3C;

  logic        clk, rst_n;
  logic        start_i, color_mode_i, cpu_rd_i, cpu_wr_i;
  logic [15:0] start_base_i, cpu_addr_i;
  logic [7:0]  cpu_rdata_o, src_rdata_i, oam_idx_o, oam_wdata_o;
  logic        mem_wr_o, src_rd_o, oam_we_o, busy_o;
  logic [15:0] src_addr_o;

  typedef struct {
    int unsigned cyc;
    int          idx;
    logic [7:0]  data;
  } exp_t;

  exp_t        q[$];
  int unsigned cyc;
  int          n_checks, n_fail;
  bit          run_mon;

  function automatic logic [7:0] src_byte(input logic [15:0] a);
    return a[7:0] ^ (a[15:8] * 8'd3) ^ 8'h5A;
  endfunction

  assign src_rdata_i = src_byte(src_addr_o);

  oam_copy_engine dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_base_i(start_base_i),
    .color_mode_i(color_mode_i), .cpu_addr_i(cpu_addr_i), .cpu_rd_i(cpu_rd_i),
    .cpu_wr_i(cpu_wr_i), .cpu_bus_rdata_i(BUSDATA), .cpu_rdata_o(cpu_rdata_o),
    .mem_wr_o(mem_wr_o), .src_rd_o(src_rd_o), .src_addr_o(src_addr_o),
    .src_rdata_i(src_rdata_i), .oam_we_o(oam_we_o), .oam_idx_o(oam_idx_o),
    .oam_wdata_o(oam_wdata_o), .busy_o(busy_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops expected table writes and compares them as they appear.
  always @(negedge clk) begin
    if (cyc >= WATCHDOG) begin
      chk(1'b0, "R8", "watchdog expired", int'(cyc), WATCHDOG);
      summary();
    end
    if (run_mon) begin
      while (q.size() > 0 && q[0].cyc < cyc) begin
        chk(1'b0, "R2", "missed write at cycle", int'(cyc), int'(q[0].cyc));
        void'(q.pop_front());
      end
      if (oam_we_o) begin
        if (q.size() == 0) begin
          chk(1'b0, "R1", "unexpected table write idx", int'(oam_idx_o), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(e.cyc == cyc, "R2", "write cycle", int'(cyc), int'(e.cyc));
          chk(oam_idx_o == 8'(e.idx) && oam_wdata_o == e.data, "R3",
              "write idx/data", {oam_idx_o, oam_wdata_o}, {8'(e.idx), e.data});
          chk(src_rd_o, "R3", "source strobe with write", int'(src_rd_o), 1);
        end
      end
    end
  end

  // Driver: issues a start and pushes the expected schedule.
  task automatic start_xfer(input logic [15:0] base, input logic color,
                            input bit accept, output int unsigned c0);
    @(negedge clk);
    color_mode_i = color;
    start_i      = 1'b1;
    start_base_i = base;
    c0 = cyc + 1;
    if (accept) begin
      while (q.size() > 0 && q[q.size()-1].cyc >= c0) void'(q.pop_back());
      for (int k = 0; k < NBYTES; k++) begin
        exp_t e;
        e.cyc  = c0 + 7 + 4*k;
        e.idx  = k;
        e.data = src_byte(base + 16'(k));
        q.push_back(e);
      end
    end
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == accept, accept ? "R8" : "R1", "busy after start",
        int'(busy_o), int'(accept));
  endtask

  // Caller positions at a negedge; access probed combinationally.
  task automatic probe(input logic [15:0] addr, input bit blocked, input string req);
    cpu_addr_i = addr;
    cpu_rd_i   = 1'b1;
    cpu_wr_i   = 1'b1;
    #1;
    chk(cpu_rdata_o == (blocked ? 8'hFF : BUSDATA), req, $sformatf("read @%h", addr),
        int'(cpu_rdata_o), int'(blocked ? 8'hFF : BUSDATA));
    chk(mem_wr_o == !blocked, req, $sformatf("write @%h", addr),
        int'(mem_wr_o), int'(!blocked));
    cpu_rd_i = 1'b0;
    cpu_wr_i = 1'b0;
  endtask

  task automatic wait_done();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    chk(!busy_o, "R8", "busy low after last byte", int'(busy_o), 0);
    probe(16'hFE00, 1'b0, "R8");
  endtask

  initial begin
    int unsigned c0;
    n_checks = 0; n_fail = 0; run_mon = 0; cyc = 0;
    rst_n = 1'b0; start_i = 1'b0; start_base_i = '0; color_mode_i = 1'b0;
    cpu_addr_i = '0; cpu_rd_i = 1'b0; cpu_wr_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_mon = 1;

    // R10 reset state, R7 idle passthrough
    chk(!busy_o && !oam_we_o && !src_rd_o, "R10", "reset strobes/busy",
        {busy_o, oam_we_o, src_rd_o}, 0);
    probe(16'hFE00, 1'b0, "R7");
    probe(16'h8000, 1'b0, "R7");

    // R1: base above limit ignored
    start_xfer(16'hF180, 1'b0, 1'b0, c0);
    repeat (20) @(negedge clk);
    chk(!busy_o, "R1", "busy after ignored start", int'(busy_o), 0);

    // R5 original, source in 0x8000 region; R4 table lock
    start_xfer(16'h8000, 1'b0, 1'b1, c0);
    // collision: CPU table write in the cycle of byte 0
    while (cyc != c0 + 7) @(negedge clk);
    chk(oam_we_o, "R4", "engine write in collision cycle", int'(oam_we_o), 1);
    probe(16'hFE00, 1'b1, "R4");
    @(negedge clk); probe(16'hFE9F, 1'b1, "R4");
    @(negedge clk); probe(16'hFEA0, 1'b0, "R4");
    @(negedge clk); probe(16'h8000, 1'b1, "R5");
    @(negedge clk); probe(16'h9FFF, 1'b1, "R5");
    @(negedge clk); probe(16'hA000, 1'b0, "R7");
    @(negedge clk); probe(16'h7FFF, 1'b0, "R7");
    wait_done();

    // R5 original, other region
    start_xfer(16'hC000, 1'b0, 1'b1, c0);
    @(negedge clk); probe(16'hA000, 1'b1, "R5");
    @(negedge clk); probe(16'hFDFF, 1'b1, "R5");
    @(negedge clk); probe(16'h9FFF, 1'b0, "R7");
    wait_done();

    // R6 colour, 0xC000 region
    start_xfer(16'hC100, 1'b1, 1'b1, c0);
    @(negedge clk); probe(16'hC000, 1'b1, "R6");
    @(negedge clk); probe(16'hFDFF, 1'b1, "R6");
    @(negedge clk); probe(16'hBFFF, 1'b0, "R7");
    wait_done();

    // R6 colour, low region; R9 restart mid-copy
    start_xfer(16'h0300, 1'b1, 1'b1, c0);
    @(negedge clk); probe(16'hA000, 1'b1, "R6");
    @(negedge clk); probe(16'hBFFF, 1'b1, "R6");
    @(negedge clk); probe(16'hC000, 1'b0, "R7");
    @(negedge clk); probe(16'h8000, 1'b0, "R7");
    repeat (50) @(negedge clk);
    start_xfer(16'h8200, 1'b1, 1'b1, c0);  // R9 restart
    @(negedge clk); probe(16'h8000, 1'b1, "R6");
    @(negedge clk); probe(16'hA000, 1'b0, "R7");
    // R9 collision: restart in the cycle of byte 159
    while (cyc != c0 + 7 + 4*(NBYTES-1) - 1) @(negedge clk);
    start_xfer(16'hF100, 1'b1, 1'b1, c0);  // R1 boundary base accepted
    chk(busy_o, "R9", "busy held across restart", int'(busy_o), 1);
    @(negedge clk); probe(16'hA000, 1'b1, "R6");
    wait_done();

    run_mon = 0;
    chk(q.size() == 0, "R3", "pending writes at end", q.size(), 0);
    summary();
  end

endmodule